// File: doc/BRIEF.md
# Address Arithmetic Scratchpad Unit

This block is the integer side of a numeric engine. It keeps a small bank of directly indexed 16-bit scratch registers and a dedicated arithmetic unit whose only job is to produce operand addresses. Every clock cycle in which a command is presented, the unit reads one scratch register, combines it with an immediate according to the opcode, and sends the result to up to two places. It can write the result back into a scratch register, and it can load it into one of three address registers. The three address registers steer the data memory, the table memory and the data pads.

The writeback to the scratch bank is retired one cycle after the command. A bypass path makes a command that reads a register being written see the new value, so dependent commands can issue back to back. The three address registers and a zero flag are the only outputs.

Top module: `addr_scratch_unit`

## Requirements
- R1: While `rst_n` is low, and after its release until the first command, `dm_addr`, `tm_addr` and `dp_addr` read 0, `zero_flag` reads 0, and every scratch register holds 0.
- R2: With A the scratch register selected by `cmd_src` and B the value of `cmd_imm`, `cmd_op` selects the result as follows: 0 gives 0, 1 gives A+1, 2 gives A-1, 3 gives A AND B, 4 gives A OR B, 5 gives A XOR B, 6 gives A+B mod 2^16, and 7 gives A.
- R3: Increment of 16'hFFFF gives 16'h0000 and decrement of 16'h0000 gives 16'hFFFF.
- R4: `cmd_asel` selects the address target: 0 loads none, 1 loads `dm_addr`, 2 loads `tm_addr`, 3 loads `dp_addr`. Address registers that are not selected keep their value.
- R5: When `cmd_wb` is 1, the result is written to the scratch register selected by `cmd_dst`, whatever the value of `cmd_asel`. When `cmd_wb` is 0, no scratch register changes.
- R6: A command that reads a register written by the command just before it sees the newly written value (write-through).
- R7: `zero_flag` is 1 exactly when the result of the most recent accepted command was 0.
- R8: While `cmd_valid` is 0, all other command inputs are ignored. The address registers, the zero flag and the scratch registers hold their values.
- R9: Each of the 16 scratch registers keeps its own value, and writing one leaves the other 15 unchanged.
- R10: The address registers and the flag show the result of a command after the first rising clock edge at which `cmd_valid` is sampled high. One command can be accepted on every cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | A command is present this cycle |
| cmd_op | input | 3 | Operation code |
| cmd_src | input | 4 | Scratch register read as operand A |
| cmd_dst | input | 4 | Scratch register written when writeback is on |
| cmd_imm | input | 16 | Immediate operand B |
| cmd_wb | input | 1 | Write the result back to the scratch bank |
| cmd_asel | input | 2 | Address register target select |
| dm_addr | output | 16 | Data memory address register |
| tm_addr | output | 16 | Table memory address register |
| dp_addr | output | 16 | Data pad address register |
| zero_flag | output | 1 | Most recent result was zero |

## Verification
The assertions assume that `rst_n` is low at the first clock edge. They also assume that whenever `cmd_valid` is high, the opcode and the select fields carry known values. The bench drives all command inputs to defined values from time zero and holds reset across the first edges. It changes inputs only on the falling edge, so each command is stable around the rising edge that accepts it. During idle cycles the bench deliberately drives arbitrary field values, which exercises R8 without breaking the assumption that valid commands are well formed.

// File: rtl/asu_pkg.sv
package asu_pkg;
  localparam int unsigned ASU_WIDTH = 16;
  localparam int unsigned ASU_DEPTH = 16;

  typedef enum logic [2:0] {
    OP_CLR = 3'd0,
    OP_INC = 3'd1,
    OP_DEC = 3'd2,
    OP_AND = 3'd3,
    OP_OR  = 3'd4,
    OP_XOR = 3'd5,
    OP_ADD = 3'd6,
    OP_MOV = 3'd7
  } asu_op_e;

  typedef enum logic [1:0] {
    TGT_NONE = 2'd0,
    TGT_DM   = 2'd1,
    TGT_TM   = 2'd2,
    TGT_DP   = 2'd3
  } asu_tgt_e;
endpackage

// File: rtl/asu_alu.sv
module asu_alu #(
  parameter int unsigned W = asu_pkg::ASU_WIDTH
) (
  input  asu_pkg::asu_op_e op,
  input  logic [W-1:0]     a,
  input  logic [W-1:0]     b,
  output logic [W-1:0]     y
);
  import asu_pkg::*;

  localparam logic [W-1:0] ONE = W'(1);

  always_comb begin
    case (op)
      OP_CLR:  y = '0;
      OP_INC:  y = a + ONE;
      OP_DEC:  y = a - ONE;
      OP_AND:  y = a & b;
      OP_OR:   y = a | b;
      OP_XOR:  y = a ^ b;
      OP_ADD:  y = a + b;
      default: y = a;
    endcase
  end
endmodule

// File: rtl/asu_regfile.sv
module asu_regfile #(
  parameter int unsigned W     = asu_pkg::ASU_WIDTH,
  parameter int unsigned DEPTH = asu_pkg::ASU_DEPTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [IW-1:0] wr_idx,
  input  logic [W-1:0]  wr_data,
  input  logic [IW-1:0] rd_idx,
  output logic [W-1:0]  rd_data
);
  logic [W-1:0] ent_q [DEPTH];

  for (genvar g = 0; g < DEPTH; g++) begin : g_ent
    logic         ld;
    logic [W-1:0] d;
    logic [W-1:0] q;

    always_comb begin
      ld = wr_en && (wr_idx == IW'(g));
      d  = ld ? wr_data : q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) q <= '0;
      else        q <= d;
    end

    assign ent_q[g] = q;
  end

  // write-through: a pending write to the read index wins
  always_comb begin
    if (wr_en && (wr_idx == rd_idx)) rd_data = wr_data;
    else                             rd_data = ent_q[rd_idx];
  end
endmodule

// File: rtl/asu_addr_bank.sv
module asu_addr_bank #(
  parameter int unsigned W    = asu_pkg::ASU_WIDTH,
  parameter int unsigned NREG = 3,
  localparam int unsigned SW  = $clog2(NREG + 1)
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   cmd_en,
  input  logic [SW-1:0]          sel,
  input  logic [W-1:0]           din,
  output logic [NREG-1:0][W-1:0] q
);
  for (genvar g = 0; g < NREG; g++) begin : g_areg
    logic         ld;
    logic [W-1:0] d;
    logic [W-1:0] r;

    always_comb begin
      ld = cmd_en && (sel == SW'(g + 1));
      d  = ld ? din : r;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= '0;
      else        r <= d;
    end

    assign q[g] = r;
  end
endmodule

// File: rtl/addr_scratch_unit.sv
module addr_scratch_unit #(
  parameter int unsigned W     = asu_pkg::ASU_WIDTH,
  parameter int unsigned DEPTH = asu_pkg::ASU_DEPTH,
  localparam int unsigned IW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          cmd_valid,
  input  logic [2:0]    cmd_op,
  input  logic [IW-1:0] cmd_src,
  input  logic [IW-1:0] cmd_dst,
  input  logic [W-1:0]  cmd_imm,
  input  logic          cmd_wb,
  input  logic [1:0]    cmd_asel,
  output logic [W-1:0]  dm_addr,
  output logic [W-1:0]  tm_addr,
  output logic [W-1:0]  dp_addr,
  output logic          zero_flag
);
  import asu_pkg::*;

  localparam int unsigned NTGT = 3;

  logic [W-1:0]  opnd_a;
  logic [W-1:0]  alu_y;

  logic          pend_en_d,  pend_en_q;
  logic [IW-1:0] pend_idx_d, pend_idx_q;
  logic [W-1:0]  pend_dat_d, pend_dat_q;
  logic          zero_d,     zero_q;

  logic [NTGT-1:0][W-1:0] areg;

  asu_regfile #(.W(W), .DEPTH(DEPTH)) u_rf (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en   (pend_en_q),
    .wr_idx  (pend_idx_q),
    .wr_data (pend_dat_q),
    .rd_idx  (cmd_src),
    .rd_data (opnd_a)
  );

  asu_alu #(.W(W)) u_alu (
    .op (asu_op_e'(cmd_op)),
    .a  (opnd_a),
    .b  (cmd_imm),
    .y  (alu_y)
  );

  asu_addr_bank #(.W(W), .NREG(NTGT)) u_ab (
    .clk    (clk),
    .rst_n  (rst_n),
    .cmd_en (cmd_valid),
    .sel    (cmd_asel),
    .din    (alu_y),
    .q      (areg)
  );

  // next state of the writeback stage and the flag
  always_comb begin
    pend_en_d  = cmd_valid && cmd_wb;
    pend_idx_d = pend_en_d ? cmd_dst : pend_idx_q;
    pend_dat_d = pend_en_d ? alu_y   : pend_dat_q;
    zero_d     = cmd_valid ? (alu_y == '0) : zero_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_en_q  <= 1'b0;
      pend_idx_q <= '0;
      pend_dat_q <= '0;
      zero_q     <= 1'b0;
    end else begin
      pend_en_q  <= pend_en_d;
      pend_idx_q <= pend_idx_d;
      pend_dat_q <= pend_dat_d;
      zero_q     <= zero_d;
    end
  end

  assign dm_addr   = areg[0];
  assign tm_addr   = areg[1];
  assign dp_addr   = areg[2];
  assign zero_flag = zero_q;
endmodule

// File: rtl/asu_checker.sv
module asu_checker #(
  parameter int unsigned W  = 16,
  parameter int unsigned IW = 4
) (
  input logic          clk,
  input logic          rst_n,
  input logic          cmd_valid,
  input logic [2:0]    cmd_op,
  input logic [1:0]    cmd_asel,
  input logic [W-1:0]  dm_addr,
  input logic [W-1:0]  tm_addr,
  input logic [W-1:0]  dp_addr,
  input logic          zero_flag
);
  p_idle_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    !cmd_valid |=> $stable(dm_addr) && $stable(tm_addr) && $stable(dp_addr) && $stable(zero_flag));

  p_no_target_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_asel == 2'd0) |=> $stable(dm_addr) && $stable(tm_addr) && $stable(dp_addr));

  p_dm_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_asel == 2'd1) |=> $stable(tm_addr) && $stable(dp_addr));

  p_tm_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_asel == 2'd2) |=> $stable(dm_addr) && $stable(dp_addr));

  p_dp_only_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_asel == 2'd3) |=> $stable(dm_addr) && $stable(tm_addr));

  p_clear_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0) |=> zero_flag);

  p_flag_tracks_dm_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_asel == 2'd1) |=> (zero_flag == (dm_addr == '0)));

  p_clear_value_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (cmd_valid && cmd_op == 3'd0 && cmd_asel == 2'd3) |=> (dp_addr == '0));
endmodule

bind addr_scratch_unit asu_checker #(.W(W), .IW(IW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .cmd_valid (cmd_valid),
  .cmd_op    (cmd_op),
  .cmd_asel  (cmd_asel),
  .dm_addr   (dm_addr),
  .tm_addr   (tm_addr),
  .dp_addr   (dp_addr),
  .zero_flag (zero_flag)
);

// File: tb/sim_addr_scratch_unit.sv
module sim_addr_scratch_unit;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_op = '0;
  logic [3:0]  cmd_src = '0;
  logic [3:0]  cmd_dst = '0;
  logic [15:0] cmd_imm = '0;
  logic        cmd_wb = 1'b0;
  logic [1:0]  cmd_asel = '0;
  logic [15:0] dm_addr, tm_addr, dp_addr;
  logic        zero_flag;

  always #10 clk = ~clk;

  addr_scratch_unit u0 (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_op(cmd_op),
    .cmd_src(cmd_src), .cmd_dst(cmd_dst), .cmd_imm(cmd_imm), .cmd_wb(cmd_wb),
    .cmd_asel(cmd_asel), .dm_addr(dm_addr), .tm_addr(tm_addr),
    .dp_addr(dp_addr), .zero_flag(zero_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  logic [15:0] m [16];
  logic [15:0] e_dm = '0, e_tm = '0, e_dp = '0;
  logic        e_z = 1'b0;

  function automatic logic [15:0] ref_op(input logic [2:0] op, input logic [15:0] a, input logic [15:0] b);
    case (op)
      3'd0: return 16'h0000;
      3'd1: return a + 16'd1;
      3'd2: return a - 16'd1;
      3'd3: return a & b;
      3'd4: return a | b;
      3'd5: return a ^ b;
      3'd6: return a + b;
      default: return a;
    endcase
  endfunction

  task automatic check(input string req);
    n_chk++;
    if ({dm_addr, tm_addr, dp_addr, zero_flag} !== {e_dm, e_tm, e_dp, e_z}) begin
      n_bad++;
      $display("FAIL %s: got dm=%h tm=%h dp=%h z=%b, want dm=%h tm=%h dp=%h z=%b",
               req, dm_addr, tm_addr, dp_addr, zero_flag, e_dm, e_tm, e_dp, e_z);
    end
  endtask

  // inputs change after a falling edge; outputs compared at the next falling edge
  task automatic cmd(input logic [2:0] op, input logic [3:0] src, input logic [3:0] dst,
                     input logic [15:0] imm, input logic wb, input logic [1:0] asel,
                     input string req);
    logic [15:0] y;
    y = ref_op(op, m[src], imm);
    cmd_valid = 1'b1; cmd_op = op; cmd_src = src; cmd_dst = dst;
    cmd_imm = imm; cmd_wb = wb; cmd_asel = asel;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 1'b0;
    if (wb) m[dst] = y;
    case (asel)
      2'd1: e_dm = y;
      2'd2: e_tm = y;
      2'd3: e_dp = y;
      default: ;
    endcase
    e_z = (y == 16'h0000);
    check(req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++; n_chk++;
    $display("FAIL watchdog: got timeout, want completion");
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 16'h0000;
    repeat (2) @(negedge clk);
    check("R1 in reset");
    rst_n = 1'b1;
    @(negedge clk);
    check("R1 after release");

    // R1, R9: every scratch register starts at zero
    for (int r = 0; r < 16; r++) cmd(3'd7, 4'(r), 4'(r), 16'h1234, 1'b0, 2'(1 + r % 3), "R1 reg reset");

    // R6: clear then OR on the same register, back to back
    for (int r = 0; r < 16; r++) begin
      cmd(3'd0, 4'(r), 4'(r), 16'hFFFF, 1'b1, 2'd0, "R2 clear");
      cmd(3'd4, 4'(r), 4'(r), 16'(r * 16'h1357 + 16'h2468), 1'b1, 2'd1, "R6 write-through");
    end

    // R9: read back each register
    for (int r = 0; r < 16; r++) cmd(3'd7, 4'(r), 4'(r), 16'h0000, 1'b0, 2'(1 + r % 3), "R9 readback");

    // R2 sweep over opcodes, registers and immediates
    for (int op = 0; op < 8; op++)
      for (int r = 0; r < 16; r++)
        for (int k = 0; k < 4; k++) begin
          logic [15:0] im;
          case (k)
            0: im = 16'h0000;
            1: im = 16'hFFFF;
            2: im = 16'h00FF ^ 16'(r << 8);
            default: im = 16'hA5A5;
          endcase
          cmd(3'(op), 4'(r), 4'((r + k + op) % 16), im, k[0], 2'((op + r + k) % 4), "R2 sweep");
        end

    // R3 wrap both ways, R7 flag on a zero result
    cmd(3'd0, 4'd0, 4'd0, 16'h0000, 1'b1, 2'd0, "R7 clear sets flag");
    cmd(3'd2, 4'd0, 4'd0, 16'h0000, 1'b1, 2'd1, "R3 decrement wraps");
    cmd(3'd1, 4'd0, 4'd0, 16'h0000, 1'b1, 2'd2, "R3 increment wraps");
    cmd(3'd7, 4'd0, 4'd0, 16'h0000, 1'b0, 2'd3, "R7 zero value held");

    // R5: writeback with no address target, then observe
    cmd(3'd6, 4'd3, 4'd9, 16'h0101, 1'b1, 2'd0, "R5 write only");
    cmd(3'd7, 4'd9, 4'd9, 16'h0000, 1'b0, 2'd2, "R5 observe");
    cmd(3'd6, 4'd4, 4'd10, 16'h0202, 1'b0, 2'd1, "R5 target only");
    cmd(3'd7, 4'd10, 4'd10, 16'h0000, 1'b0, 2'd3, "R5 unchanged");

    // R6 / R10: chained increments, one per cycle
    cmd(3'd1, 4'd5, 4'd5, 16'h0000, 1'b1, 2'd0, "R10 chain 1");
    cmd(3'd1, 4'd5, 4'd5, 16'h0000, 1'b1, 2'd0, "R6 chain 2");
    cmd(3'd1, 4'd5, 4'd5, 16'h0000, 1'b1, 2'd3, "R6 chain 3");

    // R8: idle cycles with junk fields
    for (int i = 0; i < 4; i++) begin
      cmd_valid = 1'b0; cmd_op = 3'(i); cmd_src = 4'(i); cmd_dst = 4'd5;
      cmd_imm = 16'hDEAD; cmd_wb = 1'b1; cmd_asel = 2'(i);
      @(posedge clk);
      @(negedge clk);
      check("R8 idle hold");
    end
    cmd(3'd7, 4'd5, 4'd5, 16'h0000, 1'b0, 2'd1, "R8 register untouched");

    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule